// File: doc/BRIEF.md
# Halt State Controller with Bus Status Signalling

This block follows the processor core into and out of its halt state and tells the external bus about it. A one-cycle strobe from instruction execution puts the block into halt. A strap input, sampled as a level, chooses one of two signalling schemes.

In minimum mode, three discrete status lines show the halt pattern. A single address latch enable pulse follows one clock after halt is entered, so external logic can capture the status. In maximum mode, a three-bit encoded bus status carries the halt code during a short announce window, and exactly one latch pulse closes that window. The passive code is shown at every other time.

A local bus hold, granted while the block is halted, does not end the halt. While the hold is granted the status drivers are released. When the hold ends, the whole halt announcement is issued again. An interrupt request ends the halt, and so does reset. Every pin is a plain control or status level or strobe. No data stream passes through the block, so no port has a valid/ready handshake or back-pressure.

Top module: `halt_state_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no other stimulus, `halted`=0, `ale`=0, `bus_stat`=3'b111, `{mem_io,dir_tx,stat_aux}`=3'b000 and `stat_oe`=1 (given `hold_active`=0).
- R2: `halt_strobe` high at a rising edge while not halted makes `halted` read 1 after that edge.
- R3: Each halt announcement produces exactly one `ale` pulse, one cycle wide. It appears ALE_DELAY cycles after the announcement starts (the default is 1), and only while halted.
- R4: In minimum mode (`max_mode`=0), `{mem_io,dir_tx,stat_aux}` is 3'b111 whenever halted and 3'b000 otherwise. In maximum mode these lines are 3'b000.
- R5: In maximum mode, `bus_stat` is 3'b011 from the first announce cycle up to and including the `ale` cycle. At all other times it is 3'b111. In minimum mode it is always 3'b111.
- R6: While `hold_active` is high, `stat_oe`=0 and `ale`=0. A hold granted while halted leaves `halted` at 1.
- R7: When a hold that was granted during halt is released, the announcement (R3, R5) restarts from its first cycle, in the cycle after the edge where `hold_active` is first seen low.
- R8: `intr_pending` high at an edge while halted, in any phase (announcing, quiet or held), clears `halted` after that edge.
- R9: `rst_n` low overrides every other input at once, and asynchronously returns the block to the R1 state.
- R10: `intr_pending` while running has no effect. `halt_strobe` while already halted does not restart the announcement.
- R11: A hold while running gives `stat_oe`=0 and leaves `halted`=0.
- R12: `halt_strobe` accepted while `hold_active` is high enters halt silently (no `ale`, no halt code). The announcement is made when the hold is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| max_mode | input | 1 | Strap: 1 selects encoded bus status, 0 selects discrete status lines |
| halt_strobe | input | 1 | One-cycle request to enter halt |
| hold_active | input | 1 | Local bus hold currently granted |
| intr_pending | input | 1 | Interrupt request pending |
| halted | output | 1 | Block is in halt |
| ale | output | 1 | Address latch enable pulse for the halt announcement |
| bus_stat | output | 3 | Encoded bus status (maximum mode) |
| mem_io | output | 1 | Memory/IO select status line (minimum mode) |
| dir_tx | output | 1 | Transfer direction status line (minimum mode) |
| stat_aux | output | 1 | Auxiliary status line (minimum mode) |
| stat_oe | output | 1 | Status and latch-enable driver enable; low means released |

## Verification
The bench builds the block with its default parameters: ALE_DELAY=1 and three-bit status codes of 3'b011 and 3'b111. With these values an announcement lasts two cycles, so a short pseudo-random stream of strobe, hold and interrupt levels reaches every phase crossed with every input combination many times in each mode. Directed sequences on top of this put a hold and an interrupt at each offset of the announce window. They also reset the block in the middle of a halt with all inputs active.

// File: rtl/halt_ctl_pkg.sv
package halt_ctl_pkg;
  typedef enum logic [1:0] {
    PH_RUN      = 2'd0,
    PH_ANNOUNCE = 2'd1,
    PH_QUIET    = 2'd2,
    PH_HELD     = 2'd3
  } halt_phase_e;
endpackage

// File: rtl/halt_phase_seq.sv
module halt_phase_seq
  import halt_ctl_pkg::*;
#(
  parameter int ALE_DELAY = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        halt_strobe,
  input  logic        hold_active,
  input  logic        intr_pending,
  output halt_phase_e phase,
  output logic        in_window,
  output logic        latch_slot
);
  localparam int CNT_W = (ALE_DELAY < 1) ? 1 : $clog2(ALE_DELAY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ALE_DELAY);

  halt_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_RUN: begin
        if (halt_strobe) begin
          phase_d = hold_active ? PH_HELD : PH_ANNOUNCE;
          cnt_d   = '0;
        end
      end
      default: begin
        if (intr_pending) begin
          phase_d = PH_RUN;
          cnt_d   = '0;
        end else if (hold_active) begin
          phase_d = PH_HELD;
          cnt_d   = '0;
        end else if (phase_q == PH_HELD) begin
          phase_d = PH_ANNOUNCE;
          cnt_d   = '0;
        end else if (phase_q == PH_ANNOUNCE) begin
          if (cnt_q == LAST) phase_d = PH_QUIET;
          else               cnt_d   = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase      = phase_q;
  assign in_window  = (phase_q == PH_ANNOUNCE);
  assign latch_slot = (phase_q == PH_ANNOUNCE) && (cnt_q == LAST);
endmodule

// File: rtl/halt_max_enc.sv
module halt_max_enc #(
  parameter int               STAT_W       = 3,
  parameter logic [STAT_W-1:0] HALT_CODE    = 3'b011,
  parameter logic [STAT_W-1:0] PASSIVE_CODE = 3'b111
) (
  input  logic              max_mode,
  input  logic              in_window,
  output logic [STAT_W-1:0] bus_stat
);
  always_comb begin
    bus_stat = PASSIVE_CODE;
    if (max_mode && in_window) bus_stat = HALT_CODE;
  end
endmodule

// File: rtl/halt_min_enc.sv
module halt_min_enc (
  input  logic max_mode,
  input  logic is_halted,
  output logic mem_io,
  output logic dir_tx,
  output logic stat_aux
);
  logic show;
  assign show     = !max_mode && is_halted;
  assign mem_io   = show;
  assign dir_tx   = show;
  assign stat_aux = show;
endmodule

// File: rtl/halt_state_ctl.sv
module halt_state_ctl
  import halt_ctl_pkg::*;
#(
  parameter int               ALE_DELAY    = 1,
  parameter int               STAT_W       = 3,
  parameter logic [STAT_W-1:0] HALT_CODE    = 3'b011,
  parameter logic [STAT_W-1:0] PASSIVE_CODE = 3'b111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              max_mode,
  input  logic              halt_strobe,
  input  logic              hold_active,
  input  logic              intr_pending,
  output logic              halted,
  output logic              ale,
  output logic [STAT_W-1:0] bus_stat,
  output logic              mem_io,
  output logic              dir_tx,
  output logic              stat_aux,
  output logic              stat_oe
);
  halt_phase_e phase;
  logic        in_window;
  logic        latch_slot;

  halt_phase_seq #(.ALE_DELAY(ALE_DELAY)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_strobe  (halt_strobe),
    .hold_active  (hold_active),
    .intr_pending (intr_pending),
    .phase        (phase),
    .in_window    (in_window),
    .latch_slot   (latch_slot)
  );

  assign halted  = (phase != PH_RUN);
  assign stat_oe = !hold_active;
  assign ale     = latch_slot && !hold_active;

  halt_max_enc #(
    .STAT_W       (STAT_W),
    .HALT_CODE    (HALT_CODE),
    .PASSIVE_CODE (PASSIVE_CODE)
  ) u_max (
    .max_mode  (max_mode),
    .in_window (in_window),
    .bus_stat  (bus_stat)
  );

  halt_min_enc u_min (
    .max_mode  (max_mode),
    .is_halted (halted),
    .mem_io    (mem_io),
    .dir_tx    (dir_tx),
    .stat_aux  (stat_aux)
  );
endmodule

// File: rtl/halt_state_chk.sv
module halt_state_chk #(
  parameter int               STAT_W       = 3,
  parameter logic [STAT_W-1:0] HALT_CODE    = 3'b011,
  parameter logic [STAT_W-1:0] PASSIVE_CODE = 3'b111
) (
  input logic              clk,
  input logic              rst_n,
  input logic              max_mode,
  input logic              halt_strobe,
  input logic              hold_active,
  input logic              intr_pending,
  input logic              halted,
  input logic              ale,
  input logic [STAT_W-1:0] bus_stat,
  input logic              mem_io,
  input logic              dir_tx,
  input logic              stat_aux,
  input logic              stat_oe
);
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && halt_strobe) |=> halted);
  p_ale_in_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> halted);
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  p_min_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> ({mem_io, dir_tx, stat_aux} == 3'b000));
  p_max_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (max_mode && ale) |-> (bus_stat == HALT_CODE));
  p_run_passive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> (bus_stat == PASSIVE_CODE));
  p_hold_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> stat_oe);
  p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && hold_active && !intr_pending) |=> halted);
  p_intr_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && intr_pending) |=> !halted);
endmodule

bind halt_state_ctl halt_state_chk #(
  .STAT_W       (STAT_W),
  .HALT_CODE    (HALT_CODE),
  .PASSIVE_CODE (PASSIVE_CODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .max_mode     (max_mode),
  .halt_strobe  (halt_strobe),
  .hold_active  (hold_active),
  .intr_pending (intr_pending),
  .halted       (halted),
  .ale          (ale),
  .bus_stat     (bus_stat),
  .mem_io       (mem_io),
  .dir_tx       (dir_tx),
  .stat_aux     (stat_aux),
  .stat_oe      (stat_oe)
);

// File: tb/test_halt_state_ctl.sv
module test_halt_state_ctl;
  localparam int D = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic max_mode = 1'b0;
  logic halt_strobe = 1'b0;
  logic hold_active = 1'b0;
  logic intr_pending = 1'b0;
  logic halted, ale, mem_io, dir_tx, stat_aux, stat_oe;
  logic [2:0] bus_stat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state: m_halt, m_pos (-1 held, 0..D announce, D+1 quiet)
  bit m_halt = 1'b0;
  int m_pos = 0;

  always #4 clk = ~clk;

  halt_state_ctl i_halt_state_ctl (
    .clk (clk), .rst_n (rst_n), .max_mode (max_mode),
    .halt_strobe (halt_strobe), .hold_active (hold_active),
    .intr_pending (intr_pending), .halted (halted), .ale (ale),
    .bus_stat (bus_stat), .mem_io (mem_io), .dir_tx (dir_tx),
    .stat_aux (stat_aux), .stat_oe (stat_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!m_halt) begin
      if (halt_strobe) begin
        m_halt = 1'b1;
        m_pos  = hold_active ? -1 : 0;
      end
    end else if (intr_pending) begin
      m_halt = 1'b0;
    end else if (hold_active) begin
      m_pos = -1;
    end else if (m_pos == -1) begin
      m_pos = 0;
    end else if (m_pos <= D) begin
      m_pos = m_pos + 1;
    end
  endtask

  task automatic compare_all(input string ctx);
    bit win;
    win = m_halt && m_pos >= 0 && m_pos <= D;
    chk({ctx, " R2/R8 halted"}, int'(halted), int'(m_halt));
    chk({ctx, " R3 ale"}, int'(ale), int'(m_halt && m_pos == D && !hold_active));
    chk({ctx, " R4 min status"}, int'({mem_io, dir_tx, stat_aux}),
        (!max_mode && m_halt) ? 7 : 0);
    chk({ctx, " R5 bus_stat"}, int'(bus_stat), (max_mode && win) ? 3 : 7);
    chk({ctx, " R6/R11 stat_oe"}, int'(stat_oe), int'(!hold_active));
  endtask

  // apply inputs, clock once, check
  task automatic step(input bit s, input bit h, input bit i, input string ctx);
    halt_strobe = s; hold_active = h; intr_pending = i;
    model_step();
    @(posedge clk); #1;
    compare_all(ctx);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    halt_strobe = 1'b0; hold_active = 1'b0; intr_pending = 1'b0;
    m_halt = 1'b0; m_pos = 0;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    int pulses;
    #1;
    // R1: reset state
    @(posedge clk); #1;
    compare_all("R1 in reset");
    rst_n = 1'b1;
    step(0, 0, 0, "R1 after release");

    for (int mode = 0; mode < 2; mode++) begin
      do_reset();
      max_mode = mode[0];
      // R2/R3/R5: entry and announcement, count pulses
      pulses = 0;
      step(1, 0, 0, "R2 entry");
      for (int k = 0; k < 5; k++) begin
        step(0, 0, 0, "R3 announce");
        pulses += int'(ale);
      end
      chk("R3 pulse count", pulses, 1);
      // R10: strobe while halted does not restart, intr while running ignored
      step(1, 0, 0, "R10 strobe in halt");
      chk("R10 no ale", int'(ale), 0);
      // R6/R7: hold in halt, release re-announces
      step(0, 1, 0, "R6 hold");
      step(0, 1, 0, "R6 hold");
      chk("R6 halted kept", int'(halted), 1);
      pulses = 0;
      step(0, 0, 0, "R7 release");
      chk("R7 code on release", int'(bus_stat), max_mode ? 3 : 7);
      for (int k = 0; k < 4; k++) begin
        step(0, 0, 0, "R7 re-announce");
        pulses += int'(ale);
      end
      chk("R7 one pulse", pulses, 1);
      // R8: interrupt exits
      step(0, 0, 1, "R8 exit");
      chk("R8 halted", int'(halted), 0);
      step(0, 0, 1, "R10 intr running");
      chk("R10 still running", int'(halted), 0);
      // R11: hold while running
      step(0, 1, 0, "R11 hold running");
      chk("R11 oe", int'(stat_oe), 0);
      // R12: strobe under hold
      step(1, 1, 0, "R12 silent entry");
      chk("R12 halted", int'(halted), 1);
      chk("R12 no code", int'(bus_stat), 7);
      step(0, 0, 0, "R12 announce after hold");
      chk("R12 code", int'(bus_stat), max_mode ? 3 : 7);
      // hold and intr at every offset of the window
      for (int off = 0; off <= D + 1; off++) begin
        for (int ev = 0; ev < 2; ev++) begin
          step(1, 0, 0, "R3/R8 sweep entry");
          for (int k = 0; k < off; k++) step(0, 0, 0, "R3 sweep");
          if (ev == 0) step(0, 0, 1, "R8 sweep intr");
          else begin
            step(0, 1, 0, "R6 sweep hold");
            step(0, 0, 0, "R7 sweep release");
            step(0, 0, 1, "R8 sweep intr");
          end
        end
      end
      // R9: reset mid-halt with every input active
      step(1, 0, 0, "R9 prep");
      halt_strobe = 1; hold_active = 1; intr_pending = 1;
      #1; rst_n = 1'b0; #1;
      m_halt = 1'b0; m_pos = 0;
      hold_active = 0;
      #1;
      compare_all("R9 async");
      hold_active = 1;
      @(posedge clk); #1;
      compare_all("R9 held in reset");
      rst_n = 1'b1;
      halt_strobe = 0; hold_active = 0; intr_pending = 0;
      step(0, 0, 0, "R9 released");
      // pseudo-random sweep
      lfsr = 16'hACE1 ^ 16'(mode);
      for (int n = 0; n < 4000; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[1:0] == 2'b00, lfsr[4:3] == 2'b11, lfsr[8:6] == 3'b101,
             "sweep");
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule